// File: doc/BRIEF.md
# Masked Interrupt Status Collector

This block gathers single-cycle event pulses from a card host controller into a 32-bit raw status word. A mask register selects which raw bits reach a masked view. One interrupt line is raised when the masked view is non-zero and a global enable in a control register is set. Software clears status by writing ones to either the raw view or the masked view. In both views a one clears the raw bit and a zero leaves it alone. A read-only summary word reports whether any error-class bit is pending.

A card-present level enters through a synchronizer and drives a two-state machine. The state `CD_ABSENT` moves to `CD_PRESENT` on the transition *link-up* when the synchronized level is high, and that transition raises the card-insert event. The state `CD_PRESENT` moves back to `CD_ABSENT` on the transition *link-down* when the level is low, and that transition raises the card-remove event. Otherwise each state holds.

Register word addresses are: 0 control (global enable at bit 4), 1 mask, 2 raw status, 3 masked status, 4 error summary (bit 0). Reads are combinational. Writes take effect at the next clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse on an implemented bit sets that raw bit at the next clock edge. The implemented bits are: 1 response error, 2 command done, 3 data over, 4 transmit request, 5 receive request, 6 response CRC error, 7 data CRC error, 8 response timeout, 9 data timeout, 10 data starvation, 11 FIFO run error, 12 hardware locked, 13 start-bit error, 14 auto-command done, 15 end-bit error, 16 SDIO interrupt, 30 card insert, 31 card remove.
- R2: Raw bits 0 and 17 to 29 never become set, whatever the event inputs do.
- R3: A read of address 3 returns the raw status ANDed with the mask register (address 1).
- R4: Writing to address 2 clears every raw bit whose written bit is 1. Bits written as 0 keep their value.
- R5: Writing to address 3 clears every raw bit whose written bit is 1, regardless of the mask.
- R6: `irq_o` is high exactly when control bit 4 is set and at least one masked bit is 1.
- R7: Address 4 bit 0 reads 1 exactly when any of raw bits 1, 6, 7, 8, 11, 12, 13 or 15 is set. The other bits of address 4 read 0.
- R8: With mask bit 16 clear, an SDIO event still sets raw bit 16 but does not raise `irq_o`.
- R9: If an event pulse and a clearing write hit the same bit in the same cycle, the bit is set afterwards.
- R10: A rising card-present level sets raw bit 30, and a falling level sets raw bit 31. Each appears on the third clock edge after the change.
- R11: Reset clears the raw status, the mask and the global enable, so `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| evt_i | input | 32 | Event pulses, one per status bit |
| card_present_i | input | 1 | Asynchronous card-present level |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse and a write-one-to-clear can both address the same raw bit in a single cycle. The bench provokes this by driving `evt_i` bit 2 in the same cycle as a write of ones to bits 2 and 3 of the raw view, with only bit 3 set beforehand. After that edge it expects bit 2 set and bit 3 cleared. A clocked assertion in the status bank checks that every set bit is present one cycle after it was set, with or without a clear in the same cycle.

// File: rtl/irq_status_pkg.sv
`timescale 1ns/1ps
package irq_status_pkg;

    localparam int unsigned STAT_W = 32;

    localparam int unsigned BIT_SDIO     = 16;
    localparam int unsigned BIT_CARD_IN  = 30;
    localparam int unsigned BIT_CARD_OUT = 31;
    localparam int unsigned GIE_BIT      = 4;

    // implemented status bits: 1..16, 30, 31
    localparam logic [STAT_W-1:0] IMPL_BITS = 32'hC001_FFFE;
    // error class: 1, 6, 7, 8, 11, 12, 13, 15
    localparam logic [STAT_W-1:0] ERR_BITS  = 32'h0000_B9C2;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_RAW    = 3'd2,
        SEL_MASKED = 3'd3,
        SEL_ERRSUM = 3'd4
    } reg_sel_e;

    typedef enum logic [0:0] {
        CD_ABSENT  = 1'b0,
        CD_PRESENT = 1'b1
    } cd_state_e;

endpackage

// File: rtl/card_detect_fsm.sv
`timescale 1ns/1ps
module card_detect_fsm
    import irq_status_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_present_i,
    output logic insert_o,
    output logic remove_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    cd_state_e              state_q;
    cd_state_e              state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], card_present_i};
        end
    end

    assign level = sync_q[LAST];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_ABSENT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_ABSENT:  if (level)  state_d = CD_PRESENT;
            CD_PRESENT: if (!level) state_d = CD_ABSENT;
            default:    state_d = CD_ABSENT;
        endcase
    end

    // outputs: one pulse per transition
    always_comb begin
        insert_o = 1'b0;
        remove_o = 1'b0;
        unique case (state_q)
            CD_ABSENT:  insert_o = level;
            CD_PRESENT: remove_o = !level;
            default:    ;
        endcase
    end

    // R10
    insert_then_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insert_o |=> (state_q == CD_PRESENT && !insert_o));

    // R10
    remove_then_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remove_o |=> (state_q == CD_ABSENT && !remove_o));

endmodule

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              card_in_i,
    input  logic              card_out_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] raw_o
);

    logic [STAT_W-1:0] req_vec;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] raw_q;
    logic [STAT_W-1:0] raw_d;

    always_comb begin
        req_vec = evt_i;
        req_vec[BIT_CARD_IN]  = evt_i[BIT_CARD_IN]  | card_in_i;
        req_vec[BIT_CARD_OUT] = evt_i[BIT_CARD_OUT] | card_out_i;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (IMPL_BITS[b]) begin : g_live
            assign set_vec[b] = req_vec[b];
            // setting outranks clearing
            assign raw_d[b]   = (raw_q[b] & ~clr_i[b]) | req_vec[b];
        end else begin : g_rsvd
            assign set_vec[b] = 1'b0;
            assign raw_d[b]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_d;
        end
    end

    assign raw_o = raw_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((raw_q & $past(clr_i & ~set_vec)) == '0));

endmodule

// File: rtl/irq_reg_file.sv
`timescale 1ns/1ps
module irq_reg_file
    import irq_status_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] raw_i,
    output logic [STAT_W-1:0] rdata_o,
    output logic [STAT_W-1:0] clr_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              gie_o
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(SEL_CTRL);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(SEL_MASK);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(SEL_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(SEL_MASKED);
    localparam logic [ADDR_W-1:0] A_ERRSUM = ADDR_W'(SEL_ERRSUM);

    logic [STAT_W-1:0] mask_q;
    logic              gie_q;
    logic              err_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
        end else if (we_i) begin
            if (addr_i == A_MASK) mask_q <= wdata_i;
            if (addr_i == A_CTRL) gie_q  <= wdata_i[GIE_BIT];
        end
    end

    always_comb begin
        clr_o = '0;
        if (we_i && (addr_i == A_RAW || addr_i == A_MASKED)) begin
            clr_o = wdata_i;
        end
    end

    assign err_any = |(raw_i & ERR_BITS);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:   rdata_o[GIE_BIT] = gie_q;
            A_MASK:   rdata_o = mask_q;
            A_RAW:    rdata_o = raw_i;
            A_MASKED: rdata_o = raw_i & mask_q;
            A_ERRSUM: rdata_o[0] = err_any;
            default:  rdata_o = '0;
        endcase
    end

    assign mask_o = mask_q;
    assign gie_o  = gie_q;

endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       evt_i,
    input  logic              card_present_i,
    output logic              irq_o
);

    logic              card_in;
    logic              card_out;
    logic [STAT_W-1:0] raw;
    logic [STAT_W-1:0] clr;
    logic [STAT_W-1:0] mask;
    logic              gie;

    card_detect_fsm #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_card (
        .clk           (clk),
        .rst_n         (rst_n),
        .card_present_i(card_present_i),
        .insert_o      (card_in),
        .remove_o      (card_out)
    );

    irq_status_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .card_in_i (card_in),
        .card_out_i(card_out),
        .clr_i     (clr),
        .raw_o     (raw)
    );

    irq_reg_file #(
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (reg_we),
        .addr_i (reg_addr),
        .wdata_i(reg_wdata),
        .raw_i  (raw),
        .rdata_o(reg_rdata),
        .clr_o  (clr),
        .mask_o (mask),
        .gie_o  (gie)
    );

    assign irq_o = gie & (|(raw & mask));

    // R6
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie && ((raw & mask) != '0)));

    // R3
    masked_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(SEL_MASKED)) |-> (reg_rdata == (raw & mask)));

    // R4
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(SEL_RAW) && reg_wdata == '0
         && evt_i == '0 && !card_in && !card_out) |=> $stable(raw));

endmodule

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;

    localparam logic [31:0] IMPL = 32'hC001_FFFE;
    localparam logic [31:0] ERRS = 32'h0000_B9C2;
    localparam logic [2:0]  A_CTRL = 3'd0, A_MASK = 3'd1, A_RAW = 3'd2,
                            A_MSKD = 3'd3, A_ERR = 3'd4;

    // {event pattern, mask}
    localparam int NVEC = 8;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0004, 32'h0000_0004},
        {32'h0001_FFFE, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h3FFE_0001, 32'hFFFF_FFFF},
        {32'h0000_B9C2, 32'h0000_0008},
        {32'h0001_0000, 32'hFFFE_FFFF},
        {32'h0000_0028, 32'h0000_0020},
        {32'h0000_0010, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_i = '0;
    logic        card_present_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_status_unit i_irq_status_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .evt_i         (evt_i),
        .card_present_i(card_present_i),
        .irq_o         (irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] e_raw;
        logic [31:0] e_msk;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(A_RAW, v);  check("R11 raw", v, 32'h0);
        rd(A_MASK, v); check("R11 mask", v, 32'h0);
        rd(A_CTRL, v); check("R11 ctrl", v, 32'h0);
        check("R11 irq", {31'b0, irq_o}, 32'h0);

        wr(A_CTRL, 32'h0000_0010);
        rd(A_CTRL, v); check("R6 gie readback", v, 32'h0000_0010);

        // vector table: R1 R2 R3 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            wr(A_RAW, 32'hFFFF_FFFF);
            wr(A_MASK, VEC[i][31:0]);
            pulse(VEC[i][63:32]);
            e_raw = VEC[i][63:32] & IMPL;
            e_msk = e_raw & VEC[i][31:0];
            rd(A_RAW, v);  check("R1 R2 raw", v, e_raw);
            rd(A_MSKD, v); check("R3 R8 masked", v, e_msk);
            check("R6 R8 irq", {31'b0, irq_o}, {31'b0, |e_msk});
            rd(A_ERR, v);  check("R7 error summary", v, {31'b0, |(e_raw & ERRS)});
        end

        // R4 clear through raw view, zero write keeps
        wr(A_RAW, 32'hFFFF_FFFF);
        pulse(32'h0000_0006);
        wr(A_RAW, 32'h0000_0002);
        rd(A_RAW, v); check("R4 partial clear", v, 32'h0000_0004);
        wr(A_RAW, 32'h0000_0000);
        rd(A_RAW, v); check("R4 zero write", v, 32'h0000_0004);

        // R5 clear through masked view with mask bit off
        wr(A_MASK, 32'h0);
        wr(A_MSKD, 32'h0000_0004);
        rd(A_RAW, v); check("R5 masked-view clear", v, 32'h0);

        // R6 global enable gating
        wr(A_MASK, 32'hFFFF_FFFF);
        pulse(32'h0000_0008);
        wr(A_CTRL, 32'h0);
        check("R6 irq gated off", {31'b0, irq_o}, 32'h0);
        wr(A_CTRL, 32'h0000_0010);
        check("R6 irq enabled", {31'b0, irq_o}, 32'h1);

        // R9 event and clear in the same cycle
        wr(A_RAW, 32'hFFFF_FFFF);
        pulse(32'h0000_0008);
        @(negedge clk);
        evt_i = 32'h0000_0004;
        reg_we = 1'b1; reg_addr = A_RAW; reg_wdata = 32'h0000_000C;
        @(negedge clk);
        evt_i = '0; reg_we = 1'b0; reg_wdata = '0;
        rd(A_RAW, v); check("R9 event beats clear", v, 32'h0000_0004);

        // R10 card insert and remove
        wr(A_RAW, 32'hFFFF_FFFF);
        card_present_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(A_RAW, v); check("R10 not before third edge", v, 32'h0);
        @(negedge clk);
        rd(A_RAW, v); check("R10 insert", v, 32'h4000_0000);
        wr(A_RAW, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        rd(A_RAW, v); check("R10 single insert", v, 32'h0);
        card_present_i = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_RAW, v); check("R10 remove", v, 32'h8000_0000);

        // R11 reset mid-run
        pulse(32'h0000_0002);
        rst_n = 1'b0;
        #2;
        rd(A_RAW, v);  check("R11 raw after reset", v, 32'h0);
        rd(A_MASK, v); check("R11 mask after reset", v, 32'h0);
        rd(A_CTRL, v); check("R11 ctrl after reset", v, 32'h0);
        check("R11 irq after reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule